// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block is a memory-mapped bank of 32-bit control registers. It sits behind a simple bus with separate write and read strobes, a byte address and 32-bit data. The 32 KiB address range holds two windows. The lower window, at byte offset 0, holds plain registers that a write always overwrites in full. The upper window, at byte offset 0x4000, holds alias groups of four consecutive words. The first word of a group is the register itself. The next three words let software set, clear or flip selected bits in one bus write, without reading the register first.

A parameter marks some alias groups as read-through only. In those groups the three alias words still read back the register, but a write to them leaves the register untouched. Another parameter marks the groups that hold PLL controls. Those groups come out of reset with a lock-status bit forced high, so software sees the PLLs as locked. Reset values come from parameter arrays. Read data appears one cycle after the read strobe, and an access outside both windows raises a one-cycle error flag.

Top module: `rab_bank`

## Requirements
- R1: After reset each plain register reads its value from the plain reset array. Each alias group reads its value from the alias reset array, with bit LOCK_BIT (31) also set in groups marked in PLL_MASK (groups 0 and 1 by default). rd_data and err are 0 after reset.
- R2: A write to a plain register word (byte address 4*i, i < PLAIN_WORDS) replaces the whole register. A read returns data on the cycle after rd_en, and rd_data holds its value in cycles without rd_en.
- R3: In an atomic group g (g < ATOMIC_GROUPS), a write to byte address 0x4000 + 16*g + 4 ORs the written data into the register.
- R4: In an atomic group, a write to 0x4000 + 16*g + 8 clears every register bit that is set in the written data.
- R5: In an atomic group, a write to 0x4000 + 16*g + 12 XORs the written data into the register.
- R6: A read of any of the three alias words of a group (offsets +4, +8, +12) returns the current register value.
- R7: A write to the first word of a group (0x4000 + 16*g) replaces the whole register.
- R8: In a read-through group (g >= ATOMIC_GROUPS), writes to the three alias words leave the register unchanged.
- R9: An access that is misaligned (address bits 1:0 not zero), or that falls outside both windows, reads as zero and changes no register. It drives err high for exactly the next cycle.
- R10: The forced lock bit has no protection: clearing it through an alias takes effect.
- R11: When a read and a write reach the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 15 | Byte address within the 32 KiB range |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for a rejected access |

## Verification
A wrong register value stays hidden until that register, or one of its alias words, is read. It then shows on rd_data one cycle after the read strobe, so every alias write is followed by a read of the affected group. A decode fault that sends a write to the wrong group, or lets a rejected write through, is caught by reading back the neighbouring registers and checking that they did not change. A fault in the error path shows on err in the cycle right after the access, together with a zero on rd_data.

// File: rtl/rab_pkg.sv
package rab_pkg;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;

  function automatic logic [31:0] apply_op(alias_op_e op, logic [31:0] cur, logic [31:0] d);
    case (op)
      OP_SET:  apply_op = cur | d;
      OP_CLR:  apply_op = cur & ~d;
      OP_TOG:  apply_op = cur ^ d;
      default: apply_op = d;
    endcase
  endfunction

endpackage

// File: rtl/rab_decode.sv
module rab_decode #(
  parameter int ADDR_W       = 15,
  parameter int PLAIN_WORDS  = 6,
  parameter int ALIAS_GROUPS = 5,
  localparam int WIN_W = ADDR_W - 3,
  localparam int PIW   = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GW    = (ALIAS_GROUPS > 1) ? $clog2(ALIAS_GROUPS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                plain_hit,
  output logic                alias_hit,
  output logic [PIW-1:0]      plain_idx,
  output logic [GW-1:0]       grp,
  output rab_pkg::alias_op_e  op
);
  logic             aligned;
  logic             upper;
  logic [WIN_W-1:0] off;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    upper     = addr[ADDR_W-1];
    off       = addr[ADDR_W-2:2];
    plain_hit = aligned && !upper && (off < WIN_W'(PLAIN_WORDS));
    alias_hit = aligned &&  upper && (off < WIN_W'(4 * ALIAS_GROUPS));
    plain_idx = off[PIW-1:0];
    grp       = off[GW+1:2];
    op        = rab_pkg::alias_op_e'(off[1:0]);
  end
endmodule

// File: rtl/rab_regs.sv
module rab_regs #(
  parameter int PLAIN_WORDS   = 6,
  parameter int ALIAS_GROUPS  = 5,
  parameter int ATOMIC_GROUPS = 4,
  parameter int LOCK_BIT      = 31,
  parameter logic [ALIAS_GROUPS-1:0] PLL_MASK = '0,
  parameter logic [PLAIN_WORDS-1:0][31:0]  PLAIN_RST = '0,
  parameter logic [ALIAS_GROUPS-1:0][31:0] ALIAS_RST = '0,
  localparam int PIW = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GW  = (ALIAS_GROUPS > 1) ? $clog2(ALIAS_GROUPS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             plain_hit,
  input  logic                             alias_hit,
  input  logic [PIW-1:0]                   plain_idx,
  input  logic [GW-1:0]                    grp,
  input  rab_pkg::alias_op_e               op,
  input  logic [31:0]                      wdata,
  output logic [PLAIN_WORDS-1:0][31:0]     plain_q,
  output logic [ALIAS_GROUPS-1:0][31:0]    alias_q
);
  localparam logic [31:0] LOCK_MASK = 32'(1) << LOCK_BIT;

  for (genvar i = 0; i < PLAIN_WORDS; i++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)
        plain_q[i] <= PLAIN_RST[i];
      else if (wr_en && plain_hit && plain_idx == PIW'(i))
        plain_q[i] <= wdata;
    end
  end

  for (genvar g = 0; g < ALIAS_GROUPS; g++) begin : g_alias
    localparam bit ATOMIC = (g < ATOMIC_GROUPS);
    localparam logic [31:0] RST_V = ALIAS_RST[g] | (PLL_MASK[g] ? LOCK_MASK : 32'h0);
    logic sel;
    assign sel = wr_en && alias_hit && (grp == GW'(g));
    always_ff @(posedge clk) begin
      if (rst)
        alias_q[g] <= RST_V;
      else if (sel) begin
        if (op == rab_pkg::OP_BASE)
          alias_q[g] <= wdata;
        else if (ATOMIC)
          alias_q[g] <= rab_pkg::apply_op(op, alias_q[g], wdata);
      end
    end
  end
endmodule

// File: rtl/rab_rdmux.sv
module rab_rdmux #(
  parameter int PLAIN_WORDS  = 6,
  parameter int ALIAS_GROUPS = 5,
  localparam int PIW = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GW  = (ALIAS_GROUPS > 1) ? $clog2(ALIAS_GROUPS) : 1
) (
  input  logic                          plain_hit,
  input  logic                          alias_hit,
  input  logic [PIW-1:0]                plain_idx,
  input  logic [GW-1:0]                 grp,
  input  logic [PLAIN_WORDS-1:0][31:0]  plain_q,
  input  logic [ALIAS_GROUPS-1:0][31:0] alias_q,
  output logic [31:0]                   rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < PLAIN_WORDS; i++)
      if (plain_hit && plain_idx == PIW'(i)) rdata = plain_q[i];
    for (int g = 0; g < ALIAS_GROUPS; g++)
      if (alias_hit && grp == GW'(g)) rdata = alias_q[g];
  end
endmodule

// File: rtl/rab_bank.sv
module rab_bank #(
  parameter int ADDR_W        = 15,
  parameter int PLAIN_WORDS   = 6,
  parameter int ALIAS_GROUPS  = 5,
  parameter int ATOMIC_GROUPS = 4,
  parameter int LOCK_BIT      = 31,
  parameter logic [ALIAS_GROUPS-1:0] PLL_MASK = 5'b00011,
  parameter logic [PLAIN_WORDS-1:0][31:0] PLAIN_RST = {
    32'hFFFF_FFFF, 32'h2486_0324, 32'h0001_8D00,
    32'h0000_0010, 32'h0000_0000, 32'h0401_167F},
  parameter logic [ALIAS_GROUPS-1:0][31:0] ALIAS_RST = {
    32'h0000_0001, 32'h0000_0000, 32'h1018_101B,
    32'h0001_2000, 32'h0001_3001},
  localparam int PIW = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GW  = (ALIAS_GROUPS > 1) ? $clog2(ALIAS_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              err
);
  logic                          plain_hit;
  logic                          alias_hit;
  logic [PIW-1:0]                plain_idx;
  logic [GW-1:0]                 grp;
  rab_pkg::alias_op_e            op;
  logic [PLAIN_WORDS-1:0][31:0]  plain_q;
  logic [ALIAS_GROUPS-1:0][31:0] alias_q;
  logic [31:0]                   rdata;

  rab_decode #(
    .ADDR_W(ADDR_W), .PLAIN_WORDS(PLAIN_WORDS), .ALIAS_GROUPS(ALIAS_GROUPS)
  ) u_dec (
    .addr(addr), .plain_hit(plain_hit), .alias_hit(alias_hit),
    .plain_idx(plain_idx), .grp(grp), .op(op)
  );

  rab_regs #(
    .PLAIN_WORDS(PLAIN_WORDS), .ALIAS_GROUPS(ALIAS_GROUPS),
    .ATOMIC_GROUPS(ATOMIC_GROUPS), .LOCK_BIT(LOCK_BIT), .PLL_MASK(PLL_MASK),
    .PLAIN_RST(PLAIN_RST), .ALIAS_RST(ALIAS_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .plain_hit(plain_hit),
    .alias_hit(alias_hit), .plain_idx(plain_idx), .grp(grp), .op(op),
    .wdata(wr_data), .plain_q(plain_q), .alias_q(alias_q)
  );

  rab_rdmux #(
    .PLAIN_WORDS(PLAIN_WORDS), .ALIAS_GROUPS(ALIAS_GROUPS)
  ) u_mux (
    .plain_hit(plain_hit), .alias_hit(alias_hit), .plain_idx(plain_idx),
    .grp(grp), .plain_q(plain_q), .alias_q(alias_q), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rdata;
      err <= (wr_en || rd_en) && !(plain_hit || alias_hit);
    end
  end
endmodule

// File: rtl/rab_bank_chk.sv
module rab_bank_chk #(
  parameter int ADDR_W        = 15,
  parameter int PLAIN_WORDS   = 6,
  parameter int ALIAS_GROUPS  = 5,
  parameter int ATOMIC_GROUPS = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [31:0]                   wr_data,
  input logic [31:0]                   rd_data,
  input logic                          err,
  input logic [ALIAS_GROUPS-1:0][31:0] alias_q
);
  localparam int WIN_W = ADDR_W - 3;
  localparam int GW = (ALIAS_GROUPS > 1) ? $clog2(ALIAS_GROUPS) : 1;
  localparam logic [1:0] K_NONE = 2'd0, K_SET = 2'd1, K_CLR = 2'd2, K_RO = 2'd3;

  logic             in_up;
  logic [WIN_W-1:0] woff;
  logic             ok_plain, ok_alias, is_bad;
  logic [GW-1:0]    cgrp;
  logic [1:0]       cop;
  logic [1:0]       lk;
  logic [GW-1:0]    lgrp;
  logic [31:0]      ldata, lprev, sel;

  always_comb begin
    in_up    = addr[ADDR_W-1];
    woff     = addr[ADDR_W-2:2];
    ok_plain = (addr[1:0] == 2'b00) && !in_up && (woff < WIN_W'(PLAIN_WORDS));
    ok_alias = (addr[1:0] == 2'b00) &&  in_up && (woff < WIN_W'(4 * ALIAS_GROUPS));
    is_bad   = !(ok_plain || ok_alias);
    cgrp     = woff[GW+1:2];
    cop      = woff[1:0];
    sel      = '0;
    for (int g = 0; g < ALIAS_GROUPS; g++)
      if (lgrp == GW'(g)) sel = alias_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk    <= K_NONE;
      lgrp  <= '0;
      ldata <= '0;
      lprev <= '0;
    end else begin
      lk <= K_NONE;
      if (wr_en && ok_alias && cop != 2'd0) begin
        lgrp  <= cgrp;
        ldata <= wr_data;
        for (int g = 0; g < ALIAS_GROUPS; g++)
          if (cgrp == GW'(g)) lprev <= alias_q[g];
        if (int'(cgrp) >= ATOMIC_GROUPS) lk <= K_RO;
        else if (cop == 2'd1)            lk <= K_SET;
        else if (cop == 2'd2)            lk <= K_CLR;
      end
    end
  end

  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) && is_bad |=> err); // R9
  AST_NO_IDLE_ERR: assert property (@(posedge clk) disable iff (rst)
    !(wr_en || rd_en) |=> !err); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && is_bad |=> rd_data == 32'h0); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2
  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    lk == K_SET |-> (sel & ldata) == ldata); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    lk == K_CLR |-> (sel & ldata) == 32'h0); // R4
  AST_RO_KEEP: assert property (@(posedge clk) disable iff (rst)
    lk == K_RO |-> sel == lprev); // R8
endmodule

bind rab_bank rab_bank_chk #(
  .ADDR_W(ADDR_W), .PLAIN_WORDS(PLAIN_WORDS),
  .ALIAS_GROUPS(ALIAS_GROUPS), .ATOMIC_GROUPS(ATOMIC_GROUPS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .err(err), .alias_q(alias_q)
);

// File: tb/sim_rab_bank.sv
module sim_rab_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;
  int total = 0;
  int bad = 0;

  rab_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .err(err)
  );

  always #4 clk = ~clk;

  function automatic logic [14:0] ga(int g, int o);
    return 15'(32'h4000 + 16 * g + 4 * o);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [14:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; e = err;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    logic [31:0] pexp [6] = '{32'h0401_167F, 32'h0, 32'h10, 32'h0001_8D00,
                              32'h2486_0324, 32'hFFFF_FFFF};
    logic [31:0] aexp [5] = '{32'h8001_3001, 32'h8001_2000, 32'h1018_101B,
                              32'h0, 32'h1};
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 err after reset", {31'h0, err}, 32'h0);
    for (int i = 0; i < 6; i++) begin
      rd(15'(4 * i), d, e);
      check("R1 plain reset", d, pexp[i]);
    end
    for (int g = 0; g < 5; g++) begin
      rd(ga(g, 0), d, e);
      check("R1 alias reset/lock", d, aexp[g]);
    end
  endtask

  task automatic t_plain();
    logic [31:0] d; logic e;
    wr(15'h0008, 32'hA5A5_5A5A);
    rd(15'h0008, d, e);
    check("R2 plain overwrite", d, 32'hA5A5_5A5A);
    @(negedge clk);
    check("R2 rd_data hold", rd_data, 32'hA5A5_5A5A);
    rd(15'h000C, d, e);
    check("R2 neighbour intact", d, 32'h0001_8D00);
  endtask

  task automatic t_alias_ops();
    logic [31:0] d; logic e;
    wr(ga(2, 1), 32'h0000_0F00);
    rd(ga(2, 0), d, e);
    check("R3 set alias", d, 32'h1018_1F1B);
    wr(ga(2, 2), 32'h1000_0003);
    rd(ga(2, 0), d, e);
    check("R4 clear alias", d, 32'h0018_1F18);
    wr(ga(2, 3), 32'hFFFF_0000);
    rd(ga(2, 0), d, e);
    check("R5 toggle alias", d, 32'hFFE7_1F18);
    for (int o = 1; o < 4; o++) begin
      rd(ga(2, o), d, e);
      check("R6 alias read", d, 32'hFFE7_1F18);
    end
    rd(ga(3, 0), d, e);
    check("R3 other group intact", d, 32'h0);
  endtask

  task automatic t_base_write();
    logic [31:0] d; logic e;
    wr(ga(3, 0), 32'h1234_5678);
    rd(ga(3, 0), d, e);
    check("R7 base overwrite", d, 32'h1234_5678);
    rd(ga(3, 2), d, e);
    check("R6 alias read group 3", d, 32'h1234_5678);
  endtask

  task automatic t_readthrough();
    logic [31:0] d; logic e;
    wr(ga(4, 1), 32'h0000_00F0);
    wr(ga(4, 2), 32'h0000_0001);
    wr(ga(4, 3), 32'hFFFF_FFFF);
    rd(ga(4, 0), d, e);
    check("R8 read-through group unchanged", d, 32'h1);
    rd(ga(4, 2), d, e);
    check("R8 alias reads base", d, 32'h1);
    wr(ga(4, 0), 32'h0000_0077);
    rd(ga(4, 3), d, e);
    check("R7 base write in read-through group", d, 32'h77);
  endtask

  task automatic t_lock();
    logic [31:0] d; logic e;
    wr(ga(0, 2), 32'h8000_0000);
    rd(ga(0, 0), d, e);
    check("R10 lock bit cleared", d, 32'h0001_3001);
    wr(ga(1, 3), 32'h8000_0000);
    rd(ga(1, 1), d, e);
    check("R10 lock bit toggled", d, 32'h0001_2000);
  endtask

  task automatic t_bad();
    logic [31:0] d; logic e;
    rd(15'h0018, d, e);
    check("R9 out-of-window read zero", d, 32'h0);
    check("R9 err raised", {31'h0, e}, 32'h1);
    @(negedge clk);
    check("R9 err one cycle", {31'h0, err}, 32'h0);
    rd(ga(5, 0), d, e);
    check("R9 alias gap read zero", d, 32'h0);
    check("R9 alias gap err", {31'h0, e}, 32'h1);
    wr(15'h0009, 32'hDEAD_BEEF);
    check("R9 misaligned write err", {31'h0, err}, 32'h1);
    rd(15'h0008, d, e);
    check("R9 misaligned write ignored", d, 32'hA5A5_5A5A);
    wr(15'h4002, 32'hFFFF_FFFF);
    rd(ga(0, 0), d, e);
    check("R9 misaligned alias write ignored", d, 32'h0001_3001);
    rd(15'h4001, d, e);
    check("R9 misaligned read zero", d, 32'h0);
    check("R9 misaligned read err", {31'h0, e}, 32'h1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d; logic e;
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 15'h0004; wr_data = 32'h0000_DEAD;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 read returns old value", rd_data, 32'h0);
    rd(15'h0004, d, e);
    check("R11 write landed", d, 32'h0000_DEAD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_alias_ops();
    t_base_write();
    t_readthrough();
    t_lock();
    t_bad();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule